// File: doc/BRIEF.md
# Vectored Interrupt Controller with Command-Word Mask Register

This unit sits beside a processor core and decides, at each instruction boundary, whether control should pass to an interrupt handler. It watches five request lines. The first is a non-maskable source. Three maskable sources each have a fixed handler address. The last maskable source has no address of its own and only raises a non-vectored flag.

Software controls the unit in two ways. An enable strobe sets a global interrupt-enable flag. An 8-bit command word, written with a strobe, can load the three source masks, clear the latched edge request of the highest maskable source, and update a one-bit serial output latch.

When a request wins at a boundary, the unit emits a one-cycle take pulse together with the 16-bit handler address. Accepting any request clears the enable flag. The core pushes its return address and fetches from the given address; that work is outside this block.

Top module: `vic_core`

## Requirements
- R1: After reset the enable flag is clear, all three masks are set, the serial latch is 0, and `take_irq`, `nonvec_req` and `vector_addr` are 0. No maskable source is taken until the enable strobe is given.
- R2: Each source has a fixed handler address. The non-maskable source uses 0x0024, source A uses 0x003C, source B uses 0x0034 and source C uses 0x002C.
- R3: The non-maskable source is taken whatever the enable flag and masks hold. It is captured on a rising edge, so an input held high is taken only once.
- R4: When several sources are eligible, the highest one wins. The order is non-maskable, then A, then B, then C, then the non-vectored source.
- R5: When the non-vectored source wins, `take_irq` and `nonvec_req` are both 1 and `vector_addr` is 0x0000.
- R6: Command bit 3 gates the mask update. When it is 1, bits 2, 1 and 0 load the masks of A, B and C, and a 1 blocks that source. When it is 0, the masks are left unchanged. The non-vectored source has no mask.
- R7: A command word with bit 4 set clears the pending latched request of source A.
- R8: Command bit 7 is copied to `ser_out` only when bit 6 is 1. Otherwise `ser_out` holds its value.
- R9: Requests are only evaluated in a cycle where `instr_done` is 1. `take_irq` is high for one cycle, in the cycle after that boundary. `vector_addr` is 0 whenever `take_irq` is low.
- R10: Accepting any request clears the enable flag. The flag stays clear, and no further maskable source is taken, until `ie_set` is pulsed again.
- R11: Source A is latched on its rising edge, so a short pulse is served at a later boundary. Sources B, C and the non-vectored source are level-sensitive, so a pulse that is gone before the boundary is not served.
- R12: Masking source A does not stop its edge from being latched. Unmasking it later lets the stored request be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Instruction boundary strobe; requests are evaluated here |
| ie_set | input | 1 | Strobe that sets the interrupt-enable flag |
| cmd_wr | input | 1 | Strobe that applies `cmd_word` |
| cmd_word | input | 8 | Command word: bit 7 serial data, bit 6 serial enable, bit 4 clear A, bit 3 mask enable, bits 2..0 masks of A, B, C |
| nmi_in | input | 1 | Non-maskable request, rising-edge |
| irq_a_in | input | 1 | Maskable vectored request A, rising-edge latched |
| irq_b_in | input | 1 | Maskable vectored request B, level |
| irq_c_in | input | 1 | Maskable vectored request C, level |
| irq_nv_in | input | 1 | Maskable non-vectored request, level |
| take_irq | output | 1 | One-cycle pulse: an interrupt is accepted |
| vector_addr | output | 16 | Handler address, valid while `take_irq` is 1 |
| nonvec_req | output | 1 | Set with `take_irq` when the non-vectored source wins |
| ser_out | output | 1 | Serial output data latch |

## Verification
The bench targets the cases that are easy to get wrong. A non-maskable input held high must be taken exactly once; a level-sensitive design would take it at every boundary. A command word with bit 3 clear must leave the masks alone; a design that always loads them would block source C in the later test. A pulse on source A must survive while A is masked and be served once A is unmasked, but a clear command must remove it; a design that drops edges while masked, or ignores the clear bit, serves the wrong vector. The bench also checks that no maskable source is taken after an acceptance until the enable strobe returns, and that the serial latch ignores bit 7 when bit 6 is 0.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VEC_W   = 16;
  localparam int CMD_W   = 8;
  localparam int NMASK   = 3;
  // command word bit positions
  localparam int B_SDATA = 7;
  localparam int B_SEN   = 6;
  localparam int B_CLRA  = 4;
  localparam int B_MEN   = 3;
  // mask bit positions
  localparam int M_A     = 2;
  localparam int M_B     = 1;
  localparam int M_C     = 0;

  localparam logic [VEC_W-1:0] VEC_NMI = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_A   = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_B   = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_C   = 16'h002C;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_NMI, SRC_A, SRC_B, SRC_C, SRC_NV
  } src_e;

  function automatic logic [VEC_W-1:0] vector_of(src_e s);
    case (s)
      SRC_NMI: vector_of = VEC_NMI;
      SRC_A:   vector_of = VEC_A;
      SRC_B:   vector_of = VEC_B;
      SRC_C:   vector_of = VEC_C;
      default: vector_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/vic_edge_latch.sv
module vic_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic rise;

  assign rise = lvl & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= lvl;
      pend   <= rise | (pend & ~clr);
    end
  end

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !(lvl && !prev_q)) |=> !pend);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ie_set,
  input  logic             accept,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd,
  output logic             ie,
  output logic [NMASK-1:0] mask,
  output logic             ser_out,
  output logic             clr_a
);
  assign clr_a = cmd_wr & cmd[B_CLRA];

  always_ff @(posedge clk) begin
    if (rst) begin
      ie      <= 1'b0;
      mask    <= '1;
      ser_out <= 1'b0;
    end else begin
      if (accept)      ie <= 1'b0;
      else if (ie_set) ie <= 1'b1;
      if (cmd_wr && cmd[B_MEN]) mask <= cmd[NMASK-1:0];
      if (cmd_wr && cmd[B_SEN]) ser_out <= cmd[B_SDATA];
    end
  end

  assert_ie_clear_R10: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ie);
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(cmd_wr && cmd[B_MEN]) |=> $stable(mask));
  assert_ser_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(cmd_wr && cmd[B_SEN]) |=> $stable(ser_out));
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_done,
  input  logic             ie,
  input  logic [NMASK-1:0] mask,
  input  logic             nmi_pend,
  input  logic             a_pend,
  input  logic             b_lvl,
  input  logic             c_lvl,
  input  logic             nv_lvl,
  output logic             accept,
  output src_e             sel,
  output logic             take_irq,
  output logic [VEC_W-1:0] vector,
  output logic             nonvec
);
  logic el_a, el_b, el_c, el_nv;

  assign el_a  = ie & ~mask[M_A] & a_pend;
  assign el_b  = ie & ~mask[M_B] & b_lvl;
  assign el_c  = ie & ~mask[M_C] & c_lvl;
  assign el_nv = ie & nv_lvl;

  always_comb begin
    if (nmi_pend)   sel = SRC_NMI;
    else if (el_a)  sel = SRC_A;
    else if (el_b)  sel = SRC_B;
    else if (el_c)  sel = SRC_C;
    else if (el_nv) sel = SRC_NV;
    else            sel = SRC_NONE;
  end

  assign accept = instr_done & (sel != SRC_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      take_irq <= 1'b0;
      vector   <= '0;
      nonvec   <= 1'b0;
    end else begin
      take_irq <= accept;
      vector   <= accept ? vector_of(sel) : '0;
      nonvec   <= accept & (sel == SRC_NV);
    end
  end

  assert_take_on_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(instr_done));
  assert_vec_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !take_irq |-> (vector == '0));
  assert_nonvec_shape_R5: assert property (@(posedge clk) disable iff (rst)
    nonvec |-> (take_irq && vector == '0));
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_done,
  input  logic             ie_set,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             nmi_in,
  input  logic             irq_a_in,
  input  logic             irq_b_in,
  input  logic             irq_c_in,
  input  logic             irq_nv_in,
  output logic             take_irq,
  output logic [VEC_W-1:0] vector_addr,
  output logic             nonvec_req,
  output logic             ser_out
);
  logic             ie_q, accept, clr_a_cmd, nmi_pend, a_pend;
  logic [NMASK-1:0] mask_q;
  src_e             sel;
  logic             clr_nmi, clr_a;

  assign clr_nmi = accept & (sel == SRC_NMI);
  assign clr_a   = clr_a_cmd | (accept & (sel == SRC_A));

  vic_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ie_set(ie_set), .accept(accept),
    .cmd_wr(cmd_wr), .cmd(cmd_word), .ie(ie_q), .mask(mask_q),
    .ser_out(ser_out), .clr_a(clr_a_cmd)
  );

  vic_edge_latch u_nmi_latch (
    .clk(clk), .rst(rst), .lvl(nmi_in), .clr(clr_nmi), .pend(nmi_pend)
  );

  vic_edge_latch u_a_latch (
    .clk(clk), .rst(rst), .lvl(irq_a_in), .clr(clr_a), .pend(a_pend)
  );

  vic_arbiter u_arb (
    .clk(clk), .rst(rst), .instr_done(instr_done), .ie(ie_q), .mask(mask_q),
    .nmi_pend(nmi_pend), .a_pend(a_pend), .b_lvl(irq_b_in), .c_lvl(irq_c_in),
    .nv_lvl(irq_nv_in), .accept(accept), .sel(sel), .take_irq(take_irq),
    .vector(vector_addr), .nonvec(nonvec_req)
  );

  assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (take_irq && vector_addr != VEC_NMI) |-> $past(ie_q));
endmodule

// File: tb/vic_core_bench.sv
module vic_core_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_done = 1'b0, ie_set = 1'b0, cmd_wr = 1'b0;
  logic [7:0] cmd_word = '0;
  logic nmi_in = 1'b0, irq_a_in = 1'b0, irq_b_in = 1'b0, irq_c_in = 1'b0, irq_nv_in = 1'b0;
  logic take_irq, nonvec_req, ser_out;
  logic [15:0] vector_addr;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_core u_vic_core (
    .clk(clk), .rst(rst), .instr_done(instr_done), .ie_set(ie_set),
    .cmd_wr(cmd_wr), .cmd_word(cmd_word), .nmi_in(nmi_in), .irq_a_in(irq_a_in),
    .irq_b_in(irq_b_in), .irq_c_in(irq_c_in), .irq_nv_in(irq_nv_in),
    .take_irq(take_irq), .vector_addr(vector_addr), .nonvec_req(nonvec_req),
    .ser_out(ser_out)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic enable();
    ie_set = 1'b1; tick(); ie_set = 1'b0;
  endtask

  task automatic write_cmd(logic [7:0] w);
    cmd_word = w; cmd_wr = 1'b1; tick(); cmd_wr = 1'b0; cmd_word = '0;
  endtask

  task automatic pulse_a();
    irq_a_in = 1'b1; tick(); irq_a_in = 1'b0; tick();
  endtask

  // boundary: outputs sampled one cycle after instr_done
  task automatic boundary(string req, logic exp_take, logic [15:0] exp_vec, logic exp_nv);
    instr_done = 1'b1; tick(); instr_done = 1'b0;
    chk(req, "take", take_irq, exp_take);
    chk(req, "vector", vector_addr, exp_vec);
    chk(req, "nonvec", nonvec_req, exp_nv);
  endtask

  task automatic t_reset();
    chk("R1", "take", take_irq, 0);
    chk("R1", "vector", vector_addr, 0);
    chk("R1", "ser", ser_out, 0);
    irq_b_in = 1; irq_c_in = 1; irq_nv_in = 1;
    boundary("R1", 0, 16'h0000, 0);
    irq_b_in = 0; irq_c_in = 0; irq_nv_in = 0;
  endtask

  task automatic t_nmi();
    nmi_in = 1; tick(); tick();
    boundary("R3", 1, 16'h0024, 0);   // enable clear, masks set
    boundary("R3", 0, 16'h0000, 0);   // still high, no new edge
    nmi_in = 0; tick();
  endtask

  task automatic t_vectors();
    write_cmd(8'h08);
    enable(); pulse_a();
    boundary("R2", 1, 16'h003C, 0);
    enable(); irq_b_in = 1;
    boundary("R2", 1, 16'h0034, 0);
    irq_b_in = 0; enable(); irq_c_in = 1;
    boundary("R2", 1, 16'h002C, 0);
    irq_c_in = 0;
  endtask

  task automatic t_nonvec();
    enable(); irq_nv_in = 1;
    boundary("R5", 1, 16'h0000, 1);
    irq_nv_in = 0;
  endtask

  task automatic t_priority();
    pulse_a(); irq_b_in = 1; irq_c_in = 1; irq_nv_in = 1;
    nmi_in = 1; tick(); nmi_in = 0; tick();
    boundary("R4", 1, 16'h0024, 0);
    enable(); boundary("R4", 1, 16'h003C, 0);
    enable(); boundary("R4", 1, 16'h0034, 0);
    irq_b_in = 0; enable(); boundary("R4", 1, 16'h002C, 0);
    irq_c_in = 0; enable(); boundary("R4", 1, 16'h0000, 1);
    irq_nv_in = 0;
  endtask

  task automatic t_enable_flag();
    irq_b_in = 1;
    boundary("R10", 0, 16'h0000, 0);
    tick(); boundary("R10", 0, 16'h0000, 0);
    enable(); boundary("R10", 1, 16'h0034, 0);
    irq_b_in = 0;
  endtask

  task automatic t_sampling();
    enable(); irq_c_in = 1;
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R9", "no take without boundary", take_irq, 0);
    end
    boundary("R9", 1, 16'h002C, 0);
    irq_c_in = 0;
    tick();
    chk("R9", "pulse width", take_irq, 0);
    chk("R9", "idle vector", vector_addr, 0);
  endtask

  task automatic t_masks();
    write_cmd(8'h0A); enable();
    irq_b_in = 1; irq_c_in = 1;
    boundary("R6", 1, 16'h002C, 0);
    irq_b_in = 0; irq_c_in = 0;
    write_cmd(8'h05); enable(); irq_c_in = 1;   // bit 3 clear: masks kept
    boundary("R6", 1, 16'h002C, 0);
    irq_c_in = 0;
    write_cmd(8'h0F); enable(); irq_b_in = 1;
    boundary("R6", 0, 16'h0000, 0);
    irq_nv_in = 1;
    boundary("R6", 1, 16'h0000, 1);
    irq_b_in = 0; irq_nv_in = 0;
  endtask

  task automatic t_edge_a();
    write_cmd(8'h08); pulse_a();
    write_cmd(8'h10); enable();
    boundary("R7", 0, 16'h0000, 0);
    write_cmd(8'h0C); pulse_a();
    boundary("R12", 0, 16'h0000, 0);
    write_cmd(8'h08);
    boundary("R12", 1, 16'h003C, 0);
    enable(); irq_b_in = 1; tick(); irq_b_in = 0; tick();
    boundary("R11", 0, 16'h0000, 0);
    pulse_a(); tick(); tick();
    boundary("R11", 1, 16'h003C, 0);
  endtask

  task automatic t_serial();
    write_cmd(8'hC0); chk("R8", "ser set", ser_out, 1);
    write_cmd(8'h00); chk("R8", "ser hold 1", ser_out, 1);
    write_cmd(8'h40); chk("R8", "ser clear", ser_out, 0);
    write_cmd(8'h80); chk("R8", "ser hold 0", ser_out, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_nmi();
    t_vectors();
    t_nonvec();
    t_priority();
    t_enable_flag();
    t_sampling();
    t_masks();
    t_edge_a();
    t_serial();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule